// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Tear-Free Seconds Capture

This block keeps elapsed time as two counts: a milliseconds count that runs from 0 to 999, and a 32-bit seconds count. Both advance from a one-cycle tick pulse that arrives once per millisecond. On the tick that finds the milliseconds count at its last value, the milliseconds count returns to zero and the seconds count steps up by one in the same clock cycle. The counter is meant to keep running while the rest of the system sleeps, so software can use it as its persistent time base.

Software reaches the block over a simple 32-bit register bus. A request with the write flag low is a read. Reading the milliseconds register also copies the live seconds count into a separate shadow register in the same cycle. Software reads milliseconds first and the shadow second, then forms the time as seconds × 1000 + milliseconds. Because the shadow was loaded at the exact instant the milliseconds value was taken, the pair never tears across a seconds boundary. Software can also load a new seconds value by writing the live seconds register.

Top module: `rtc_shadow_top`

## Requirements
- R1: After a synchronous reset, the milliseconds count, the live seconds count and the shadow seconds all read as zero, and `rvalid_o` is low.
- R2: Each `tick_i` pulse raises the milliseconds count by one. Without a tick the count holds. The count never reaches 1000.
- R3: A tick that arrives while milliseconds equals 999 sets milliseconds to 0 and raises live seconds by one, both on the same clock edge.
- R4: A read of offset 0x10 returns the milliseconds count on `rdata_o`, zero-extended to 32 bits, with `rvalid_o` high in the next cycle.
- R5: A read of offset 0x10 loads the shadow with the live seconds value of that same cycle. A read of offset 0x0C returns the shadow.
- R6: The shadow changes only on a read of offset 0x10. Between two such reads it holds, even while live seconds advances.
- R7: When a tick and a read of offset 0x10 fall in the same cycle, the returned milliseconds and the captured shadow are both the values from before the tick.
- R8: A write to offset 0x08 loads live seconds with `wdata_i`. If a rollover tick falls in the same cycle, the written value wins, and the milliseconds count still wraps to 0.
- R9: Writes to offset 0x0C, to offset 0x10 and to any unmapped offset change no register.
- R10: The live seconds count wraps from 0xFFFFFFFF to 0 on rollover, with no other effect.
- R11: A read of offset 0x08 returns live seconds. A read of any unmapped offset returns zero. `rvalid_o` is high exactly in the cycle after a read request and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle millisecond pulse |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
Every counter update (the milliseconds increment, the rollover into seconds, a seconds load and a shadow capture) takes effect on the clock edge that samples the stimulus. Read data and `rvalid_o` come out of one register stage, so they are due exactly one edge after the request. The bench drives all inputs on the falling edge and samples outputs on the next falling edge. It advances a behavioural model on each rising edge, using the same sampled inputs, and compares the bus outputs against that model in every cycle. The directed reads for each requirement are timed to the same one-edge latency. The case where a tick and a read land in the same cycle is driven on purpose, so that the pre-tick capture rule is checked in that cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFS_SEC_LIVE   = 8'h08;
  localparam logic [7:0] OFS_SEC_SHADOW = 8'h0C;
  localparam logic [7:0] OFS_MSEC       = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LIVE,
    SEL_SHADOW,
    SEL_MSEC
  } reg_sel_e;
endpackage

// File: rtl/rtc_ms_counter.sv
module rtc_ms_counter #(
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned MS_W       = $clog2(MS_PER_SEC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  output logic [MS_W-1:0] ms_o,
  output logic            wrap_o
);
  localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

  logic [MS_W-1:0] cnt_q;

  // pulse in the cycle where the next edge rolls the count over
  assign wrap_o = tick_i && (cnt_q == LAST);
  assign ms_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] cnt_q;

  assign sec_o = cnt_q;

  // a software load takes priority over the rollover increment
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MS_W-1:0]   ms_i,
  output logic              load_sec_o,
  output logic [SEC_W-1:0]  load_val_o,
  output logic [SEC_W-1:0]  shadow_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  reg_sel_e         sel;
  logic             rd;
  logic [SEC_W-1:0] shadow_q;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_SEC_LIVE))        sel = SEL_LIVE;
    else if (addr_i == ADDR_W'(OFS_SEC_SHADOW)) sel = SEL_SHADOW;
    else if (addr_i == ADDR_W'(OFS_MSEC))       sel = SEL_MSEC;
    else                                        sel = SEL_NONE;
  end

  assign rd         = req_i && !we_i;
  assign load_sec_o = req_i && we_i && (sel == SEL_LIVE);
  assign load_val_o = wdata_i[SEC_W-1:0];
  assign shadow_o   = shadow_q;

  // the read data and the shadow both take the values from before the edge
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) begin
        case (sel)
          SEL_LIVE:   rdata_o <= DATA_W'(sec_i);
          SEL_SHADOW: rdata_o <= DATA_W'(shadow_q);
          SEL_MSEC:   rdata_o <= DATA_W'(ms_i);
          default:    rdata_o <= '0;
        endcase
        if (sel == SEL_MSEC) shadow_q <= sec_i;
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top #(
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned MS_W = $clog2(MS_PER_SEC);

  logic [MS_W-1:0]  ms_cnt;
  logic             ms_wrap;
  logic [SEC_W-1:0] sec_cnt;
  logic [SEC_W-1:0] shadow_sec;
  logic             sec_load;
  logic [SEC_W-1:0] sec_load_val;

  rtc_ms_counter #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_ms (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ms_o(ms_cnt), .wrap_o(ms_wrap)
  );

  rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .inc_i(ms_wrap), .load_i(sec_load),
    .load_val_i(sec_load_val), .sec_o(sec_cnt)
  );

  rtc_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)) u_bus (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sec_i(sec_cnt), .ms_i(ms_cnt),
    .load_sec_o(sec_load), .load_val_o(sec_load_val), .shadow_o(shadow_sec),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk #(
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MS_W       = $clog2(MS_PER_SEC)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rvalid_o,
  input logic [MS_W-1:0]   ms_cnt,
  input logic [SEC_W-1:0]  sec_cnt,
  input logic [SEC_W-1:0]  shadow_sec
);
  logic rd_ms, wr_live, rd_any;
  assign rd_any  = req_i && !we_i;
  assign rd_ms   = rd_any && (addr_i == ADDR_W'(8'h10));
  assign wr_live = req_i && we_i && (addr_i == ADDR_W'(8'h08));

  AST_MS_RANGE: assert property (@(posedge clk) disable iff (rst)
    ms_cnt < MS_W'(MS_PER_SEC)); // R2
  AST_MS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(ms_cnt)); // R2
  AST_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
    (tick_i && ms_cnt == MS_W'(MS_PER_SEC - 1) && !wr_live)
      |=> (ms_cnt == '0) && (sec_cnt == $past(sec_cnt) + SEC_W'(1))); // R3
  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    rd_ms |=> shadow_sec == $past(sec_cnt)); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_ms |=> $stable(shadow_sec)); // R6
  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_live |=> sec_cnt == $past(wdata_i[SEC_W-1:0])); // R8
  AST_RVALID_HI: assert property (@(posedge clk) disable iff (rst)
    rd_any |=> rvalid_o); // R11
  AST_RVALID_LO: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> !rvalid_o); // R11
endmodule

bind rtc_shadow_top rtc_shadow_chk #(
  .MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o),
  .ms_cnt(ms_cnt), .sec_cnt(sec_cnt), .shadow_sec(shadow_sec)
);

// File: tb/rtc_shadow_top_tb.sv
module rtc_shadow_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  rtc_shadow_top u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // behavioural reference model
  int unsigned m_ms, m_sec, m_sh, m_rdata;
  bit          m_rvalid;

  always @(posedge clk) begin
    if (rst) begin
      m_ms = 0; m_sec = 0; m_sh = 0; m_rdata = 0; m_rvalid = 0;
    end else begin
      bit wrap;
      m_rvalid = req_i && !we_i;
      if (req_i && !we_i) begin
        if (addr_i == 8'h08)      m_rdata = m_sec;
        else if (addr_i == 8'h0C) m_rdata = m_sh;
        else if (addr_i == 8'h10) m_rdata = m_ms;
        else                      m_rdata = 0;
        if (addr_i == 8'h10) m_sh = m_sec;
      end
      wrap = 0;
      if (tick_i) begin
        if (m_ms == 999) begin m_ms = 0; wrap = 1; end
        else m_ms = m_ms + 1;
      end
      if (req_i && we_i && addr_i == 8'h08) m_sec = wdata_i;
      else if (wrap) m_sec = m_sec + 1;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R11 rvalid model", {31'd0, rvalid_o}, {31'd0, m_rvalid});
      if (m_rvalid) check("R4 rdata model", rdata_o, m_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, bit with_tick, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; tick_i = with_tick;
    @(negedge clk);
    d = rdata_o;
    req_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v, bit with_tick);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = v; tick_i = with_tick;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=timeout exp=finish");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rvalid after reset", {31'd0, rvalid_o}, 32'd0);
    rd(8'h08, 0, d); check("R1 live seconds", d, 32'd0);
    rd(8'h0C, 0, d); check("R1 shadow", d, 32'd0);
    rd(8'h10, 0, d); check("R1 msec", d, 32'd0);

    ticks(5);
    rd(8'h10, 0, d); check("R2 msec after 5 ticks", d, 32'd5);
    idle(3);
    rd(8'h10, 0, d); check("R2 msec holds", d, 32'd5);

    ticks(994);
    rd(8'h10, 0, d); check("R3 msec at 999", d, 32'd999);
    rd(8'h08, 0, d); check("R3 seconds before wrap", d, 32'd0);
    ticks(1);
    rd(8'h10, 0, d); check("R3 msec wrapped", d, 32'd0);
    rd(8'h08, 0, d); check("R3 seconds stepped", d, 32'd1);

    ticks(250);
    rd(8'h10, 0, d); check("R4 msec read", d, 32'd250);
    rd(8'h0C, 0, d); check("R5 shadow captured", d, 32'd1);
    ticks(1000);
    rd(8'h0C, 0, d); check("R6 shadow held", d, 32'd1);
    rd(8'h08, 0, d); check("R11 live seconds", d, 32'd2);

    ticks(749);
    rd(8'h10, 1, d); check("R7 pre-tick msec", d, 32'd999);
    rd(8'h0C, 0, d); check("R7 pre-tick shadow", d, 32'd2);
    rd(8'h08, 0, d); check("R7 live after tick", d, 32'd3);
    rd(8'h10, 0, d); check("R7 msec after tick", d, 32'd0);

    wr(8'h08, 32'h0000_1234, 0);
    rd(8'h08, 0, d); check("R8 seconds loaded", d, 32'h1234);
    wr(8'h0C, 32'h0000_AAAA, 0);
    wr(8'h10, 32'h0000_0055, 0);
    wr(8'h20, 32'hDEAD_BEEF, 0);
    rd(8'h0C, 0, d); check("R9 shadow unchanged", d, 32'd3);
    rd(8'h10, 0, d); check("R9 msec unchanged", d, 32'd0);
    rd(8'h08, 0, d); check("R9 seconds unchanged", d, 32'h1234);

    ticks(999);
    wr(8'h08, 32'h0000_0077, 1);
    rd(8'h08, 0, d); check("R8 write beats rollover", d, 32'h77);
    rd(8'h10, 0, d); check("R8 msec still wraps", d, 32'd0);

    ticks(999);
    wr(8'h08, 32'hFFFF_FFFF, 0);
    ticks(1);
    rd(8'h08, 0, d); check("R10 seconds wrap", d, 32'd0);

    rd(8'h04, 0, d); check("R11 unmapped read", d, 32'd0);
    idle(1);
    check("R11 rvalid low when idle", {31'd0, rvalid_o}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule